// File: doc/BRIEF.md
# ATA PIO Access Timing Sequencer

This block runs a single programmed-I/O cycle on the device side of an ATA bus each time it receives a start pulse. It captures the access description presented with the pulse: a 4-bit register address, the transfer direction and the currently selected drive. It then picks one of three programmable timing sets. It walks the cycle through an address-setup phase, a strobe phase, an optional wait stretch driven by the drive's ready line, and an end-of-cycle recovery phase. The block drives the read or write strobe, the output enable of the 16-bit data bus and a one-clock completion pulse. On a read it also captures the word the drive returned.

Each timing set holds four 8-bit phase lengths (address setup, strobe width, write-data hold and recovery) and a bit that lets the ready line stretch the strobe. One set serves command-register accesses at compatible timing. The other two give faster data-port timing, one per drive. A per-drive fast-timing enable decides whether a data-port access may use that drive's fast set. While the block is reset, the latched timing values hold a PIO mode 0 profile for a 100 MHz clock: setup 6, strobe 28, hold 2 and recovery 23 cycles, so that T1 + T2 + recovery covers the 600 ns cycle time.

An upstream controller issues a start pulse and waits for the completion pulse before it presents the next access. A start pulse that arrives while a cycle is in progress is dropped.

Top module: `ata_pio_seq`

## Requirements
- R1: While `rst_n` is low, or for the cycle after `clr` is high, the block returns to idle: `rd_strobe`, `wr_strobe`, `dd_oe` and `done` are low, and a cycle that was in progress never signals completion.
- R2: An access to address 4'b1000 (the data port) uses drive 1's fast set when `dev_sel` is 1 and `fast_en1` is 1. It uses drive 0's fast set when `dev_sel` is 0 and `fast_en0` is 1. Every other access uses the command set.
- R3: The start pulse is sampled at a clock edge. The address-setup phase then lasts setup+1 cycles, and no strobe is asserted during it.
- R4: The strobe phase lasts active+1 cycles. `wr_dir`=1 asserts `wr_strobe` and `wr_dir`=0 asserts `rd_strobe`. The other strobe stays low throughout.
- R5: The recovery phase lasts recov+1 cycles. `done` is then high for exactly one cycle, the (setup+active+recov+4)-th cycle after the start edge.
- R6: `dd_oe` is never high on a read. On a write it is high through setup and strobe, and for `hold` further cycles after the strobe falls.
- R7: On a read, `rdata` takes the value of `dd_in` at the clock edge where `rd_strobe` falls, and keeps that value afterwards.
- R8: When the active set's ready-enable bit is 1 and the synchronised `iordy` is low at the end of the strobe phase, the strobe stays high. It falls at the third clock edge after `iordy` rises, because `iordy` passes through two flip-flops.
- R9: When the active set's ready-enable bit is 0, a low `iordy` does not change the cycle timing.
- R10: A start pulse that arrives while a cycle is in progress is ignored. It does not extend the cycle and does not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous abort to idle, active high |
| go | input | 1 | Start pulse for one access |
| addr | input | 4 | Register address of the access |
| wr_dir | input | 1 | 1 = write, 0 = read |
| dev_sel | input | 1 | Selected drive (0 or 1) |
| fast_en0 | input | 1 | Allow fast data-port timing for drive 0 |
| fast_en1 | input | 1 | Allow fast data-port timing for drive 1 |
| cmd_setup | input | TWIDTH | Command set: address-setup length |
| cmd_active | input | TWIDTH | Command set: strobe length |
| cmd_hold | input | TWIDTH | Command set: write-data hold length |
| cmd_recov | input | TWIDTH | Command set: recovery length |
| cmd_rdy_en | input | 1 | Command set: ready-line stretch enable |
| d0_setup | input | TWIDTH | Drive 0 fast set: address-setup length |
| d0_active | input | TWIDTH | Drive 0 fast set: strobe length |
| d0_hold | input | TWIDTH | Drive 0 fast set: hold length |
| d0_recov | input | TWIDTH | Drive 0 fast set: recovery length |
| d0_rdy_en | input | 1 | Drive 0 fast set: ready-line stretch enable |
| d1_setup | input | TWIDTH | Drive 1 fast set: address-setup length |
| d1_active | input | TWIDTH | Drive 1 fast set: strobe length |
| d1_hold | input | TWIDTH | Drive 1 fast set: hold length |
| d1_recov | input | TWIDTH | Drive 1 fast set: recovery length |
| d1_rdy_en | input | 1 | Drive 1 fast set: ready-line stretch enable |
| iordy | input | 1 | Drive ready line, asynchronous |
| dd_in | input | 16 | Data bus from the drive |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| dd_oe | output | 1 | Output enable for the data bus |
| rdata | output | 16 | Word captured on a read |
| done | output | 1 | One-cycle completion pulse |

## Verification
All results are timed from the clock edge that samples `go`. The first strobe cycle is cycle setup+2 after that edge and the last is cycle setup+active+2. `done` comes in cycle setup+active+recov+4. The captured read word is the `dd_in` value present at the edge that ends the last strobe cycle. When the strobe is stretched, it falls in the third cycle after `iordy` rises. The bench drives inputs and samples outputs on the falling clock edge. It numbers every sampled cycle from the start edge and compares each observed phase length and event position with the value computed from the timing set it expects. It also changes `dd_in` every cycle, so that only a capture at the right edge yields the expected word.

// File: rtl/ata_pio_pkg.sv
// Package: types shared by the PIO access sequencer.
// Assumes: the 4-bit register address space of the device-side bus.
package ata_pio_pkg;

    // Address of the 16-bit data port, the only address with fast timing
    localparam logic [3:0] DATA_PORT_ADDR = 4'b1000;

    // Phases of one access
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_WAIT,
        PH_RECOV
    } pio_phase_e;

    // Which timing set governs an access
    typedef enum logic [1:0] {
        TS_CMD,
        TS_DEV0,
        TS_DEV1
    } tset_e;

endpackage

// File: rtl/ata_pio_tsel.sv
// Module: timing-set selector.
// Picks one of three timing sets from the access address, the selected drive
// and the per-drive fast-timing enables. Purely combinational.
// Assumes: the result is only used while the sequencer is idle and accepting go.
module ata_pio_tsel
    import ata_pio_pkg::*;
#(
    parameter int unsigned TWIDTH = 8
) (
    input  logic [3:0]        addr,
    input  logic              dev_sel,
    input  logic              fast_en0,
    input  logic              fast_en1,
    input  logic [TWIDTH-1:0] cmd_setup,
    input  logic [TWIDTH-1:0] cmd_active,
    input  logic [TWIDTH-1:0] cmd_hold,
    input  logic [TWIDTH-1:0] cmd_recov,
    input  logic              cmd_rdy_en,
    input  logic [TWIDTH-1:0] d0_setup,
    input  logic [TWIDTH-1:0] d0_active,
    input  logic [TWIDTH-1:0] d0_hold,
    input  logic [TWIDTH-1:0] d0_recov,
    input  logic              d0_rdy_en,
    input  logic [TWIDTH-1:0] d1_setup,
    input  logic [TWIDTH-1:0] d1_active,
    input  logic [TWIDTH-1:0] d1_hold,
    input  logic [TWIDTH-1:0] d1_recov,
    input  logic              d1_rdy_en,
    output logic [TWIDTH-1:0] sel_setup,
    output logic [TWIDTH-1:0] sel_active,
    output logic [TWIDTH-1:0] sel_hold,
    output logic [TWIDTH-1:0] sel_recov,
    output logic              sel_rdy_en
);

    tset_e which;

    // Decide which set applies: data port and the selected drive's fast bit
    always_comb begin : pick_set
        which = TS_CMD;
        if (addr == DATA_PORT_ADDR) begin
            if (dev_sel && fast_en1)
                which = TS_DEV1;
            else if (!dev_sel && fast_en0)
                which = TS_DEV0;
        end
    end

    // Route the chosen set's values to the outputs
    always_comb begin : route_set
        unique case (which)
            TS_DEV0: begin
                sel_setup = d0_setup;  sel_active = d0_active;
                sel_hold  = d0_hold;   sel_recov  = d0_recov;
                sel_rdy_en = d0_rdy_en;
            end
            TS_DEV1: begin
                sel_setup = d1_setup;  sel_active = d1_active;
                sel_hold  = d1_hold;   sel_recov  = d1_recov;
                sel_rdy_en = d1_rdy_en;
            end
            default: begin
                sel_setup = cmd_setup; sel_active = cmd_active;
                sel_hold  = cmd_hold;  sel_recov  = cmd_recov;
                sel_rdy_en = cmd_rdy_en;
            end
        endcase
    end

endmodule

// File: rtl/ata_pio_sync.sv
// Module: multi-flop synchroniser for the asynchronous ready line.
// Assumes: the input is level-like; reset value is "ready" so that an idle
// bus never looks stalled.
module ata_pio_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through STAGES flip-flops
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin : shift_one
                if (!rst_n) chain <= '1;
                else        chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin : shift_many
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ata_pio_phase.sv
// Module: phase sequencer for one PIO access.
// Latches the chosen timing set and direction when go arrives in idle, then
// counts setup, strobe (with optional ready-line stretch) and recovery.
// Each phase lasts its programmed value plus one cycle. Write-data hold runs
// concurrently with recovery.
// Assumes: hold <= recov + 1 for the full hold to be visible; go while busy
// is ignored.
module ata_pio_phase
    import ata_pio_pkg::*;
#(
    parameter int unsigned TWIDTH    = 8,
    parameter int unsigned RST_SETUP = 6,
    parameter int unsigned RST_ACT   = 28,
    parameter int unsigned RST_HOLD  = 2,
    parameter int unsigned RST_RECOV = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr_dir,
    input  logic [TWIDTH-1:0] in_setup,
    input  logic [TWIDTH-1:0] in_active,
    input  logic [TWIDTH-1:0] in_hold,
    input  logic [TWIDTH-1:0] in_recov,
    input  logic              in_rdy_en,
    input  logic              rdy_sync,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              dd_oe,
    output logic              capture,
    output logic              done
);

    pio_phase_e        phase;
    logic [TWIDTH-1:0] cnt;
    logic [TWIDTH-1:0] hold_cnt;
    logic [TWIDTH-1:0] act_q, hold_q, recov_q;
    logic              rdy_en_q;
    logic              dir_q;
    logic              strobe_on;
    logic              strobe_end;

    // Strobe finishes when its count is spent and no stretch applies, or when
    // a stretch sees the ready line return
    always_comb begin : end_of_strobe
        strobe_end = 1'b0;
        if (phase == PH_STROBE)
            strobe_end = (cnt == '0) && !(rdy_en_q && !rdy_sync);
        else if (phase == PH_WAIT)
            strobe_end = rdy_sync;
    end

    // Main phase state machine with its shared down-counter
    always_ff @(posedge clk) begin : phase_fsm
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            hold_cnt <= '0;
            done     <= 1'b0;
            dir_q    <= 1'b0;
            rdy_en_q <= 1'b0;
            act_q    <= TWIDTH'(RST_ACT);
            hold_q   <= TWIDTH'(RST_HOLD);
            recov_q  <= TWIDTH'(RST_RECOV);
            cnt      <= TWIDTH'(RST_SETUP);
        end else begin
            done <= 1'b0;
            if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
            unique case (phase)
                PH_IDLE: if (go) begin
                    phase    <= PH_SETUP;
                    cnt      <= in_setup;
                    act_q    <= in_active;
                    hold_q   <= in_hold;
                    recov_q  <= in_recov;
                    rdy_en_q <= in_rdy_en;
                    dir_q    <= wr_dir;
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= act_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE, PH_WAIT: begin
                    if (strobe_end) begin
                        phase    <= PH_RECOV;
                        cnt      <= recov_q;
                        hold_cnt <= hold_q;
                    end else if (phase == PH_STROBE && cnt == '0) begin
                        phase <= PH_WAIT;
                    end else if (phase == PH_STROBE) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign strobe_on = (phase == PH_STROBE) || (phase == PH_WAIT);
    assign rd_strobe = strobe_on && !dir_q;
    assign wr_strobe = strobe_on && dir_q;
    assign dd_oe     = dir_q && ((phase == PH_SETUP) || strobe_on ||
                                 ((phase == PH_RECOV) && (hold_cnt != '0)));
    assign capture   = strobe_end && !dir_q;

    // Only one strobe at a time
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    // Completion is a single-cycle pulse
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Completion comes only with both strobes released
    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_strobe && !wr_strobe));

    // A stretched strobe only exists when the latched set allows it
    assert_wait_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |-> rdy_en_q);

    // A busy sequencer never restarts from a strobe phase
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_on |=> (phase != PH_SETUP));

endmodule

// File: rtl/ata_pio_seq.sv
// Module: ATA PIO access timing sequencer (top).
// Selects a timing set, runs one device-side PIO cycle per go pulse, and
// captures read data when the read strobe ends.
// Assumes: the caller waits for done before issuing the next go; clr is a
// synchronous abort that acts like reset.
module ata_pio_seq #(
    parameter int unsigned TWIDTH      = 8,
    parameter int unsigned MODE0_SETUP = 6,
    parameter int unsigned MODE0_ACT   = 28,
    parameter int unsigned MODE0_HOLD  = 2,
    parameter int unsigned MODE0_RECOV = 23,
    parameter int unsigned RDY_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic [3:0]        addr,
    input  logic              wr_dir,
    input  logic              dev_sel,
    input  logic              fast_en0,
    input  logic              fast_en1,
    input  logic [TWIDTH-1:0] cmd_setup,
    input  logic [TWIDTH-1:0] cmd_active,
    input  logic [TWIDTH-1:0] cmd_hold,
    input  logic [TWIDTH-1:0] cmd_recov,
    input  logic              cmd_rdy_en,
    input  logic [TWIDTH-1:0] d0_setup,
    input  logic [TWIDTH-1:0] d0_active,
    input  logic [TWIDTH-1:0] d0_hold,
    input  logic [TWIDTH-1:0] d0_recov,
    input  logic              d0_rdy_en,
    input  logic [TWIDTH-1:0] d1_setup,
    input  logic [TWIDTH-1:0] d1_active,
    input  logic [TWIDTH-1:0] d1_hold,
    input  logic [TWIDTH-1:0] d1_recov,
    input  logic              d1_rdy_en,
    input  logic              iordy,
    input  logic [15:0]       dd_in,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              dd_oe,
    output logic [15:0]       rdata,
    output logic              done
);

    logic              rst_int_n;
    logic [TWIDTH-1:0] s_setup, s_active, s_hold, s_recov;
    logic              s_rdy_en;
    logic              rdy_sync;
    logic              capture;

    assign rst_int_n = rst_n && !clr;

    ata_pio_tsel #(.TWIDTH(TWIDTH)) u_tsel (
        .addr       (addr),
        .dev_sel    (dev_sel),
        .fast_en0   (fast_en0),
        .fast_en1   (fast_en1),
        .cmd_setup  (cmd_setup),
        .cmd_active (cmd_active),
        .cmd_hold   (cmd_hold),
        .cmd_recov  (cmd_recov),
        .cmd_rdy_en (cmd_rdy_en),
        .d0_setup   (d0_setup),
        .d0_active  (d0_active),
        .d0_hold    (d0_hold),
        .d0_recov   (d0_recov),
        .d0_rdy_en  (d0_rdy_en),
        .d1_setup   (d1_setup),
        .d1_active  (d1_active),
        .d1_hold    (d1_hold),
        .d1_recov   (d1_recov),
        .d1_rdy_en  (d1_rdy_en),
        .sel_setup  (s_setup),
        .sel_active (s_active),
        .sel_hold   (s_hold),
        .sel_recov  (s_recov),
        .sel_rdy_en (s_rdy_en)
    );

    ata_pio_sync #(.STAGES(RDY_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .async_in (iordy),
        .sync_out (rdy_sync)
    );

    ata_pio_phase #(
        .TWIDTH    (TWIDTH),
        .RST_SETUP (MODE0_SETUP),
        .RST_ACT   (MODE0_ACT),
        .RST_HOLD  (MODE0_HOLD),
        .RST_RECOV (MODE0_RECOV)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .go        (go),
        .wr_dir    (wr_dir),
        .in_setup  (s_setup),
        .in_active (s_active),
        .in_hold   (s_hold),
        .in_recov  (s_recov),
        .in_rdy_en (s_rdy_en),
        .rdy_sync  (rdy_sync),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .dd_oe     (dd_oe),
        .capture   (capture),
        .done      (done)
    );

    // Hold the word returned by the drive at the end of a read strobe
    always_ff @(posedge clk) begin : read_capture
        if (!rst_int_n)
            rdata <= '0;
        else if (capture)
            rdata <= dd_in;
    end

    // The captured word is the bus value at the edge that ended the read strobe
    assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
        ($fell(rd_strobe) && $past(rst_n) && !$past(clr)) |-> (rdata == $past(dd_in)));

    // The data bus is never driven while reading
    assert_no_oe_on_read_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
        rd_strobe |-> !dd_oe);

    // An abort leaves the bus quiet on the next cycle
    assert_clear_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!rd_strobe && !wr_strobe && !dd_oe && !done));

endmodule

// File: tb/sim_ata_pio_seq.sv
module sim_ata_pio_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;
    localparam int NSAMP = 60;

    // Bench timing sets: index 0 command, 1 drive 0, 2 drive 1
    localparam int EXP_SETUP [3] = '{1, 0, 2};
    localparam int EXP_ACT   [3] = '{3, 2, 1};
    localparam int EXP_HOLD  [3] = '{1, 0, 1};
    localparam int EXP_RECOV [3] = '{2, 1, 3};

    // Vector fields: [9:6] addr, [5] dir, [4] dev_sel, [3] fast0, [2] fast1, [1:0] expected set
    localparam int NVEC = 8;
    localparam logic [9:0] VEC [NVEC] = '{
        {4'b1000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1},
        {4'b1000, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2},
        {4'b1000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        {4'b1000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
        {4'b0111, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0},
        {4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0},
        {4'b1000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1},
        {4'b1000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic go = 1'b0;
    logic [3:0] addr = '0;
    logic wr_dir = 1'b0;
    logic dev_sel = 1'b0;
    logic fast_en0 = 1'b0;
    logic fast_en1 = 1'b0;
    logic iordy = 1'b1;
    logic [15:0] dd_in = '0;
    logic rd_strobe, wr_strobe, dd_oe, done;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_seq #(.TWIDTH(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .go(go), .addr(addr),
        .wr_dir(wr_dir), .dev_sel(dev_sel), .fast_en0(fast_en0), .fast_en1(fast_en1),
        .cmd_setup(TW'(EXP_SETUP[0])), .cmd_active(TW'(EXP_ACT[0])),
        .cmd_hold(TW'(EXP_HOLD[0])), .cmd_recov(TW'(EXP_RECOV[0])), .cmd_rdy_en(1'b1),
        .d0_setup(TW'(EXP_SETUP[1])), .d0_active(TW'(EXP_ACT[1])),
        .d0_hold(TW'(EXP_HOLD[1])), .d0_recov(TW'(EXP_RECOV[1])), .d0_rdy_en(1'b0),
        .d1_setup(TW'(EXP_SETUP[2])), .d1_active(TW'(EXP_ACT[2])),
        .d1_hold(TW'(EXP_HOLD[2])), .d1_recov(TW'(EXP_RECOV[2])), .d1_rdy_en(1'b0),
        .iordy(iordy), .dd_in(dd_in),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .dd_oe(dd_oe),
        .rdata(rdata), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one access and measure it over NSAMP falling-edge samples
    task automatic run_access(input logic [3:0] a, input logic dir, input logic ds,
                              input logic f0, input logic f1,
                              input int rise_at, input int go_again_at, input int clr_at,
                              output int lead, output int slen, output int dpos,
                              output int oecnt, output int wrong, output int dcnt);
        bit seen;
        lead = 0; slen = 0; dpos = 0; oecnt = 0; wrong = 0; dcnt = 0; seen = 0;
        @(negedge clk);
        addr = a; wr_dir = dir; dev_sel = ds; fast_en0 = f0; fast_en1 = f1;
        go = 1'b1;
        for (int n = 1; n <= NSAMP; n++) begin
            @(negedge clk);
            go = 1'b0;
            clr = 1'b0;
            dd_in = 16'hC000 | 16'(n);
            if ((dir ? wr_strobe : rd_strobe)) begin
                slen++;
                seen = 1;
            end else if (!seen) begin
                lead++;
            end
            if ((dir ? rd_strobe : wr_strobe)) wrong++;
            if (dd_oe) oecnt++;
            if (done) begin
                dcnt++;
                if (dpos == 0) dpos = n;
            end
            if (n == rise_at) iordy = 1'b1;
            if (n == go_again_at) go = 1'b1;
            if (n == clr_at) clr = 1'b1;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int lead, slen, dpos, oecnt, wrong, dcnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!rd_strobe && !wr_strobe, "R1 strobes in reset", int'(rd_strobe | wr_strobe), 0);
        check(!dd_oe && !done, "R1 oe/done in reset", int'(dd_oe | done), 0);
        rst_n = 1'b1;

        // Vector table: set selection and phase timing
        for (int v = 0; v < NVEC; v++) begin
            int s;
            logic d;
            s = int'(VEC[v][1:0]);
            d = VEC[v][5];
            run_access(VEC[v][9:6], d, VEC[v][4], VEC[v][3], VEC[v][2], 0, 0, 0,
                       lead, slen, dpos, oecnt, wrong, dcnt);
            check(lead == EXP_SETUP[s] + 1, $sformatf("R3 R2 setup vec%0d", v), lead, EXP_SETUP[s] + 1);
            check(slen == EXP_ACT[s] + 1, $sformatf("R4 R2 strobe vec%0d", v), slen, EXP_ACT[s] + 1);
            check(wrong == 0, $sformatf("R4 other strobe vec%0d", v), wrong, 0);
            check(dpos == EXP_SETUP[s] + EXP_ACT[s] + EXP_RECOV[s] + 4,
                  $sformatf("R5 R2 done pos vec%0d", v), dpos,
                  EXP_SETUP[s] + EXP_ACT[s] + EXP_RECOV[s] + 4);
            check(dcnt == 1, $sformatf("R5 done count vec%0d", v), dcnt, 1);
            if (d) begin
                check(oecnt == EXP_SETUP[s] + EXP_ACT[s] + 2 + EXP_HOLD[s],
                      $sformatf("R6 oe write vec%0d", v), oecnt,
                      EXP_SETUP[s] + EXP_ACT[s] + 2 + EXP_HOLD[s]);
            end else begin
                check(oecnt == 0, $sformatf("R6 oe read vec%0d", v), oecnt, 0);
                // R7: dd_in at the edge after the last strobe sample
                check(rdata == (16'hC000 | 16'(EXP_SETUP[s] + EXP_ACT[s] + 2)),
                      $sformatf("R7 capture vec%0d", v), int'(rdata),
                      int'(16'hC000 | 16'(EXP_SETUP[s] + EXP_ACT[s] + 2)));
            end
        end

        // R8: command set stretches while iordy low, ends 3 edges after rise at sample 20
        iordy = 1'b0;
        run_access(4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 20, 0, 0,
                   lead, slen, dpos, oecnt, wrong, dcnt);
        check(slen == 20, "R8 stretched strobe length", slen, 20);
        check(dpos == 26, "R8 done after stretch", dpos, 26);
        check(rdata == 16'hC016, "R8 R7 capture after stretch", int'(rdata), int'(16'hC016));

        // R9: drive 0 fast set has stretch disabled, iordy low has no effect
        iordy = 1'b0;
        run_access(4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 0,
                   lead, slen, dpos, oecnt, wrong, dcnt);
        check(slen == EXP_ACT[1] + 1, "R9 no stretch", slen, EXP_ACT[1] + 1);
        check(dpos == EXP_SETUP[1] + EXP_ACT[1] + EXP_RECOV[1] + 4, "R9 done pos", dpos,
              EXP_SETUP[1] + EXP_ACT[1] + EXP_RECOV[1] + 4);
        iordy = 1'b1;

        // R10: extra go during the strobe is ignored
        run_access(4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 0, 3, 0,
                   lead, slen, dpos, oecnt, wrong, dcnt);
        check(dcnt == 1, "R10 single completion", dcnt, 1);
        check(slen == EXP_ACT[0] + 1, "R10 single strobe", slen, EXP_ACT[0] + 1);
        check(dpos == EXP_SETUP[0] + EXP_ACT[0] + EXP_RECOV[0] + 4, "R10 done pos", dpos,
              EXP_SETUP[0] + EXP_ACT[0] + EXP_RECOV[0] + 4);

        // R1: abort during the strobe returns to idle without completion
        run_access(4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 3,
                   lead, slen, dpos, oecnt, wrong, dcnt);
        check(slen == 1, "R1 abort cuts strobe", slen, 1);
        check(dcnt == 0, "R1 abort no done", dcnt, 0);
        check(rdata == 16'h0000, "R1 abort clears capture", int'(rdata), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule